// File: doc/BRIEF.md
# Scaled-Index Effective Address Generator

This unit forms a 32-bit effective address from up to three terms: a base value, an index value multiplied by 1, 2, 4 or 8, and a signed displacement. The base and the index arrive as register-file read data, each with its own enable, so that either term can be left out. The displacement arrives as a raw field together with a size code. The unit sign-extends the field to the full address width before the add.

Each operation is accepted through a valid/ready handshake and produces one registered result a cycle later. The result is marked either as a memory request or as a register write. The register-write form is the load-effective-address case, which never touches memory. An operation that names the stack-pointer register (register number 4) as its index is refused. It produces a one-cycle illegal-operand pulse and no result.

Top module: `agu_eff_addr`

## Requirements
- R1: The result equals base term + scaled index term + extended displacement, truncated to 32 bits. It appears on `out_addr` with `out_valid` high in the cycle after the operation is accepted (`in_valid && in_ready` at a clock edge).
- R2: `scale_code` values 0, 1, 2 and 3 multiply the index term by 1, 2, 4 and 8 respectively.
- R3: `disp_size` selects the displacement extension. Code 0 means no displacement, so the value is zero. Code 1 sign-extends `disp_raw[7:0]`, code 2 sign-extends `disp_raw[15:0]`, and code 3 uses all 32 bits. Bits above the selected field have no effect on the result.
- R4: With `base_en` low the base term is zero. With `index_en` low the index term is zero, whatever the values on `base_val` and `index_val`.
- R5: An accepted operation with `index_en` high and `index_sel` equal to 4 raises `illegal` for exactly one cycle, in the cycle after acceptance, and produces no `out_valid`. With `index_en` low, `index_sel` equal to 4 is accepted normally.
- R6: While `out_valid` is high, exactly one of `mem_req` and `reg_wr` is high. `reg_wr` is high when the operation had `lea_mode` set, and `mem_req` is high otherwise. Both are low when `out_valid` is low.
- R7: While `out_valid` is high and `out_ready` is low, `in_ready` is low and the result, its valid flag and its kind are all held unchanged.
- R8: After reset `out_valid`, `mem_req`, `reg_wr` and `illegal` are low and `in_ready` is high.
- R9: A new operation is accepted in the same cycle that a held result is consumed, so one result per cycle is sustained while `out_ready` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| base_en | input | 1 | Base term present |
| base_val | input | 32 | Base register read data |
| index_en | input | 1 | Index term present |
| index_sel | input | 3 | Register number of the index (4 is refused) |
| index_val | input | 32 | Index register read data |
| scale_code | input | 2 | Index multiplier code (0..3 gives 1, 2, 4, 8) |
| disp_size | input | 2 | Displacement size code (0 none, 1 byte, 2 half, 3 word) |
| disp_raw | input | 32 | Raw displacement field |
| lea_mode | input | 1 | Send the result to a register, not to memory |
| out_ready | input | 1 | Consumer takes the result |
| out_valid | output | 1 | Result present |
| out_addr | output | 32 | Effective address |
| mem_req | output | 1 | Result is a memory access request |
| reg_wr | output | 1 | Result is a register write (address-only form) |
| illegal | output | 1 | Refused operation (stack pointer as index) |

## Verification
Two functions of this block can fall in the same clock edge: draining a result that a stalled consumer held, and accepting the next operation. The bench provokes this by stalling the consumer with a second operation waiting at the input, then releasing `out_ready`. It judges that the held address stayed fixed during the stall. It then checks that, one cycle after the release, the waiting operation's address is on the output with no gap and no duplicate. A refused stack-pointer index is also issued straight after legal operations, to show that the illegal pulse and the loss of `out_valid` line up with the refused operation only.

// File: rtl/agu_pkg.sv
package agu_pkg;

  typedef enum logic [1:0] {
    DISP_NONE = 2'd0,
    DISP_B8   = 2'd1,
    DISP_B16  = 2'd2,
    DISP_FULL = 2'd3
  } disp_sz_e;

  // Index operand that names the stack pointer is refused.
  function automatic logic index_refused(input logic en, input logic [2:0] sel,
                                         input logic [2:0] sp_sel);
    return en && (sel == sp_sel);
  endfunction

endpackage

// File: rtl/agu_disp_ext.sv
module agu_disp_ext #(
  parameter int ADDR_W = 32
) (
  input  logic [ADDR_W-1:0]  raw,
  input  agu_pkg::disp_sz_e  size,
  output logic [ADDR_W-1:0]  ext
);
  localparam int NARROW = 2;   // byte and halfword forms

  logic [ADDR_W-1:0] narrow_ext [NARROW];

  for (genvar g = 0; g < NARROW; g++) begin : g_narrow
    localparam int FW = 8 << g;
    assign narrow_ext[g] = {{(ADDR_W-FW){raw[FW-1]}}, raw[FW-1:0]};
  end

  always_comb begin
    case (size)
      agu_pkg::DISP_NONE: ext = '0;
      agu_pkg::DISP_B8:   ext = narrow_ext[0];
      agu_pkg::DISP_B16:  ext = narrow_ext[1];
      default:            ext = raw;
    endcase
  end
endmodule

// File: rtl/agu_index_scaler.sv
module agu_index_scaler #(
  parameter int ADDR_W  = 32,
  parameter int SCALE_W = 2
) (
  input  logic [ADDR_W-1:0]  idx,
  input  logic [SCALE_W-1:0] code,
  output logic [ADDR_W-1:0]  scaled
);
  localparam int NSTEP = 1 << SCALE_W;

  logic [ADDR_W-1:0] cand [NSTEP];

  for (genvar g = 0; g < NSTEP; g++) begin : g_shift
    assign cand[g] = idx << g;
  end

  assign scaled = cand[code];
endmodule

// File: rtl/agu_out_stage.sv
module agu_out_stage #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              acc_ok,
  input  logic              acc_bad,
  input  logic [ADDR_W-1:0] nxt_addr,
  input  logic              nxt_lea,
  input  logic              out_ready,
  output logic              stage_free,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic              out_lea,
  output logic              illegal
);
  assign stage_free = !out_valid || out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_addr  <= '0;
      out_lea   <= 1'b0;
      illegal   <= 1'b0;
    end else begin
      illegal <= acc_bad;
      if (stage_free) begin
        out_valid <= acc_ok;
        if (acc_ok) begin
          out_addr <= nxt_addr;
          out_lea  <= nxt_lea;
        end
      end
    end
  end
endmodule

// File: rtl/agu_eff_addr.sv
module agu_eff_addr #(
  parameter int ADDR_W    = 32,
  parameter int SEL_W     = 3,
  parameter int SCALE_W   = 2,
  parameter int STACK_SEL = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              base_en,
  input  logic [ADDR_W-1:0] base_val,
  input  logic              index_en,
  input  logic [SEL_W-1:0]  index_sel,
  input  logic [ADDR_W-1:0] index_val,
  input  logic [SCALE_W-1:0] scale_code,
  input  logic [1:0]        disp_size,
  input  logic [ADDR_W-1:0] disp_raw,
  input  logic              lea_mode,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [ADDR_W-1:0] out_addr,
  output logic              mem_req,
  output logic              reg_wr,
  output logic              illegal
);
  // Named internal events, visible to the bound checker.
  logic              accept;
  logic              idx_blocked;
  logic              acc_ok;
  logic              acc_bad;
  logic              out_lea;
  logic [ADDR_W-1:0] base_term;
  logic [ADDR_W-1:0] index_term;
  logic [ADDR_W-1:0] index_scaled;
  logic [ADDR_W-1:0] disp_ext;
  logic [ADDR_W-1:0] sum;

  assign accept      = in_valid && in_ready;
  assign idx_blocked = agu_pkg::index_refused(index_en, 3'(index_sel), 3'(STACK_SEL));
  assign acc_ok      = accept && !idx_blocked;
  assign acc_bad     = accept && idx_blocked;

  assign base_term  = base_en  ? base_val  : '0;
  assign index_term = index_en ? index_val : '0;

  agu_index_scaler #(.ADDR_W(ADDR_W), .SCALE_W(SCALE_W)) scaler_i (
    .idx    (index_term),
    .code   (scale_code),
    .scaled (index_scaled)
  );

  agu_disp_ext #(.ADDR_W(ADDR_W)) disp_i (
    .raw  (disp_raw),
    .size (agu_pkg::disp_sz_e'(disp_size)),
    .ext  (disp_ext)
  );

  assign sum = base_term + index_scaled + disp_ext;

  agu_out_stage #(.ADDR_W(ADDR_W)) stage_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .acc_ok     (acc_ok),
    .acc_bad    (acc_bad),
    .nxt_addr   (sum),
    .nxt_lea    (lea_mode),
    .out_ready  (out_ready),
    .stage_free (in_ready),
    .out_valid  (out_valid),
    .out_addr   (out_addr),
    .out_lea    (out_lea),
    .illegal    (illegal)
  );

  assign mem_req = out_valid && !out_lea;
  assign reg_wr  = out_valid &&  out_lea;
endmodule

// File: rtl/agu_eff_addr_chk.sv
module agu_eff_addr_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_ready,
  input logic              acc_ok,
  input logic              acc_bad,
  input logic              out_ready,
  input logic              out_valid,
  input logic [ADDR_W-1:0] out_addr,
  input logic              mem_req,
  input logic              reg_wr,
  input logic              illegal
);
  a_r1_latency: assert property (@(posedge clk) disable iff (!rst_n)
    acc_ok |=> out_valid);

  a_r5_refused: assert property (@(posedge clk) disable iff (!rst_n)
    acc_bad |=> (illegal && !out_valid));

  a_r5_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |=> !illegal || $past(acc_bad));

  a_r6_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $onehot({mem_req, reg_wr}));

  a_r6_idle_kind: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> !(mem_req || reg_wr));

  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_addr) && $stable(reg_wr)));

  a_r7_no_take: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |-> !in_ready);

  a_r9_drain_take: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready) |-> in_ready);
endmodule

bind agu_eff_addr agu_eff_addr_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_ready  (in_ready),
  .acc_ok    (acc_ok),
  .acc_bad   (acc_bad),
  .out_ready (out_ready),
  .out_valid (out_valid),
  .out_addr  (out_addr),
  .mem_req   (mem_req),
  .reg_wr    (reg_wr),
  .illegal   (illegal)
);

// File: tb/agu_eff_addr_tb.sv
module agu_eff_addr_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        base_en = 1'b0;
  logic [31:0] base_val = '0;
  logic        index_en = 1'b0;
  logic [2:0]  index_sel = '0;
  logic [31:0] index_val = '0;
  logic [1:0]  scale_code = '0;
  logic [1:0]  disp_size = '0;
  logic [31:0] disp_raw = '0;
  logic        lea_mode = 1'b0;
  logic        out_ready = 1'b1;
  logic        out_valid;
  logic [31:0] out_addr;
  logic        mem_req;
  logic        reg_wr;
  logic        illegal;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  agu_eff_addr dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .base_en(base_en), .base_val(base_val), .index_en(index_en),
    .index_sel(index_sel), .index_val(index_val), .scale_code(scale_code),
    .disp_size(disp_size), .disp_raw(disp_raw), .lea_mode(lea_mode),
    .out_ready(out_ready), .out_valid(out_valid), .out_addr(out_addr),
    .mem_req(mem_req), .reg_wr(reg_wr), .illegal(illegal)
  );

  // Independent model: multiply for the scale, size casts for the displacement.
  function automatic logic [31:0] model(input logic be, input logic [31:0] b,
                                        input logic ie, input logic [31:0] i,
                                        input logic [1:0] sc, input logic [1:0] sz,
                                        input logic [31:0] d);
    logic signed [31:0] dv;
    case (sz)
      2'd0:    dv = 32'sd0;
      2'd1:    dv = 32'($signed(d[7:0]));
      2'd2:    dv = 32'($signed(d[15:0]));
      default: dv = $signed(d);
    endcase
    return (be ? b : 32'd0) + (ie ? i : 32'd0) * (32'd1 << sc) + 32'(dv);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic set_op(input logic be, input logic [31:0] b, input logic ie,
                        input logic [2:0] isel, input logic [31:0] i,
                        input logic [1:0] sc, input logic [1:0] sz,
                        input logic [31:0] d, input logic lea);
    in_valid = 1'b1; base_en = be; base_val = b; index_en = ie; index_sel = isel;
    index_val = i; scale_code = sc; disp_size = sz; disp_raw = d; lea_mode = lea;
  endtask

  // One operation, result checked one cycle after acceptance.
  task automatic run_op(input string req, input logic be, input logic [31:0] b,
                        input logic ie, input logic [2:0] isel, input logic [31:0] i,
                        input logic [1:0] sc, input logic [1:0] sz, input logic [31:0] d,
                        input logic lea, input logic [31:0] exp);
    @(negedge clk);
    set_op(be, b, ie, isel, i, sc, sz, d, lea);
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1, {req, " valid"}, 32'(out_valid), 32'd1);
    check(out_addr === exp, {req, " addr"}, out_addr, exp);
    check(out_addr === model(be, b, ie, i, sc, sz, d), {req, " model"}, out_addr,
          model(be, b, ie, i, sc, sz, d));
    check(reg_wr === lea && mem_req === !lea, {req, " R6 kind"},
          {30'd0, reg_wr, mem_req}, {30'd0, lea, !lea});
    @(negedge clk);
    check(out_valid === 1'b0, {req, " R1 single result"}, 32'(out_valid), 32'd0);
  endtask

  task automatic t_reset;
    check(out_valid === 1'b0 && illegal === 1'b0 && mem_req === 1'b0 && reg_wr === 1'b0,
          "R8 reset outputs", {28'd0, out_valid, illegal, mem_req, reg_wr}, 32'd0);
    check(in_ready === 1'b1, "R8 reset ready", 32'(in_ready), 32'd1);
  endtask

  task automatic t_vectors;
    run_op("R1 base+disp8",   1, 32'hF000, 0, 3'd1, 32'h0,    2'd0, 2'd1, 32'h8,  0, 32'hF008);
    run_op("R1 base+index",   1, 32'hF000, 1, 3'd1, 32'h100,  2'd0, 2'd0, 32'h0,  0, 32'hF100);
    run_op("R2 scale 4",      1, 32'hF000, 1, 3'd1, 32'h100,  2'd2, 2'd0, 32'h0,  0, 32'hF400);
    run_op("R4 no base",      0, 32'h1234, 1, 3'd2, 32'hF000, 2'd1, 2'd2, 32'h80, 0, 32'h1E080);
    run_op("R2 scale 8",      1, 32'h10,   1, 3'd6, 32'h3,    2'd3, 2'd0, 32'h0,  0, 32'h28);
    run_op("R4 no index",     1, 32'h500,  0, 3'd3, 32'hFFFF, 2'd3, 2'd0, 32'h0,  0, 32'h500);
  endtask

  task automatic t_disp;
    run_op("R3 byte negative", 1, 32'h100, 0, 3'd0, 32'h0, 2'd0, 2'd1, 32'h12345FF0, 0, 32'hF0);
    run_op("R3 half negative", 1, 32'h10000, 0, 3'd0, 32'h0, 2'd0, 2'd2, 32'hABCD8000, 0, 32'h8000);
    run_op("R3 none ignored",  1, 32'h40, 0, 3'd0, 32'h0, 2'd0, 2'd0, 32'hDEADBEEF, 0, 32'h40);
    run_op("R3 full word",     1, 32'h40, 0, 3'd0, 32'h0, 2'd0, 2'd3, 32'hFFFFFFC0, 0, 32'h0);
    run_op("R1 wrap",          1, 32'hFFFFFFF0, 1, 3'd1, 32'h80000000, 2'd1, 2'd3, 32'h20, 0, 32'h10);
  endtask

  task automatic t_lea;
    run_op("R6 lea form", 1, 32'h2000, 1, 3'd7, 32'h4, 2'd2, 2'd1, 32'h4, 1, 32'h2014);
  endtask

  task automatic t_illegal;
    @(negedge clk);
    set_op(1, 32'h100, 1, 3'd4, 32'h8, 2'd0, 2'd0, 32'h0, 0);
    @(negedge clk);
    in_valid = 1'b0;
    check(illegal === 1'b1, "R5 illegal raised", 32'(illegal), 32'd1);
    check(out_valid === 1'b0, "R5 no result", 32'(out_valid), 32'd0);
    @(negedge clk);
    check(illegal === 1'b0, "R5 one-cycle pulse", 32'(illegal), 32'd0);
    run_op("R5 sel4 index off", 1, 32'h100, 0, 3'd4, 32'h8, 2'd0, 2'd0, 32'h0, 0, 32'h100);
  endtask

  task automatic t_stall_overlap;
    logic [31:0] ea = model(1, 32'hA000, 1, 32'h10, 2'd1, 2'd1, 32'h4);
    logic [31:0] eb = model(1, 32'hB000, 0, 32'h0,  2'd0, 2'd1, 32'hFC);
    @(negedge clk);
    out_ready = 1'b0;
    set_op(1, 32'hA000, 1, 3'd1, 32'h10, 2'd1, 2'd1, 32'h4, 0);
    @(negedge clk);
    set_op(1, 32'hB000, 0, 3'd0, 32'h0, 2'd0, 2'd1, 32'hFC, 1);
    check(out_valid === 1'b1 && out_addr === ea, "R7 first held", out_addr, ea);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(out_addr === ea && out_valid === 1'b1 && mem_req === 1'b1, "R7 stable while stalled",
            out_addr, ea);
      check(in_ready === 1'b0, "R7 ready low", 32'(in_ready), 32'd0);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid === 1'b1 && out_addr === eb, "R9 taken on drain", out_addr, eb);
    check(reg_wr === 1'b1, "R9 second kind", 32'(reg_wr), 32'd1);
    @(negedge clk);
    check(out_valid === 1'b0, "R9 no duplicate", 32'(out_valid), 32'd0);
  endtask

  task automatic t_back_to_back;
    logic [31:0] e0 = model(1, 32'h1000, 1, 32'h1, 2'd0, 2'd0, 32'h0);
    logic [31:0] e1 = model(1, 32'h2000, 1, 32'h1, 2'd3, 2'd0, 32'h0);
    @(negedge clk);
    set_op(1, 32'h1000, 1, 3'd2, 32'h1, 2'd0, 2'd0, 32'h0, 0);
    @(negedge clk);
    check(out_addr === e0 && out_valid === 1'b1, "R9 stream 0", out_addr, e0);
    set_op(1, 32'h2000, 1, 3'd2, 32'h1, 2'd3, 2'd0, 32'h0, 0);
    @(negedge clk);
    check(out_addr === e1 && out_valid === 1'b1, "R9 stream 1", out_addr, e1);
    set_op(1, 32'h3000, 1, 3'd4, 32'h1, 2'd0, 2'd0, 32'h0, 0);
    @(negedge clk);
    in_valid = 1'b0;
    check(illegal === 1'b1 && out_valid === 1'b0, "R5 refused in stream",
          {30'd0, illegal, out_valid}, 32'd2);
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_vectors();
    t_disp();
    t_lea();
    t_illegal();
    t_stall_overlap();
    t_back_to_back();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=complete");
      finish_run();
    end
  end
endmodule